// File: doc/BRIEF.md
# ADC Scan Sequencer

This block chains analog-to-digital conversions without processor involvement. A small table in an internal word memory holds command words and receives conversion results. Every time the converter reports a finished conversion, the sequencer runs one short transfer cycle on its own. It reads the command word the table pointer addresses and parks it in a holding register. It moves the pointer forward by one word (two byte addresses) and writes the conversion result there. Finally it writes the parked command into the converter's command register, which starts the next conversion.

Software sets up a control block through a load strobe. The control block holds a mode code, a pointer-update flag, a cycle count and a byte-address table pointer. With the update flag clear, every cycle reuses the same command and overwrites the same result slot. With the flag set, the pointer moves on to the next command/result pair after each cycle. The count drops by one per cycle. When it reaches zero, the block raises a one-cycle done interrupt and switches itself off. A host port gives access to the table memory whenever no transfer cycle is running.

Top module: `adc_scan_seq`

## Requirements
- R1: A transfer cycle starts only when `conv_done` is sampled high while `seq_en` is high and `busy` is low. A strobe that arrives while the block is disabled or already busy is ignored and leaves no trace in the table.
- R2: The result is sampled in the same clock as the strobe. The command word is fetched from the word at byte pointer P (word index P/2).
- R3: The sampled result is written to byte address P+2, in the third cycle after the strobe.
- R4: `cmd_wr` pulses for one clock, four cycles after the strobe, carrying the fetched command on `cmd_word`. `busy` is high in cycles one to four after the strobe and low again in cycle five.
- R5: When the update flag is 0, the pointer is unchanged after a cycle. The same command is re-issued every cycle and the result slot P+2 is overwritten.
- R6: When the update flag is 1, the pointer ends each cycle at P+4, so successive cycles use consecutive command/result pairs.
- R7: The cycle count drops by one per cycle. After the cycle that takes it to zero, `done_irq` is high for exactly one clock (the cycle after that cycle's `cmd_wr`) and `seq_en` is low. Later strobes are ignored.
- R8: After reset the block is idle and disabled. A `cfg_load` enables it only if `cfg_mode` is 3'b110 and `cfg_count` is nonzero; any other mode or a zero count leaves it disabled. Bit 0 of `cfg_ptr` is cleared on load. A load while `busy` is high is ignored.
- R9: Host writes while `busy` is low store `host_wdata` at word `host_addr`. A host read returns the word on `host_rdata` one cycle later. Host accesses while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the control block |
| cfg_mode | input | 3 | Mode code, 3'b110 selects scan |
| cfg_updt | input | 1 | Pointer-update flag |
| cfg_count | input | CNT_W | Number of cycles to run |
| cfg_ptr | input | ADDR_W | Table pointer, byte address |
| conv_done | input | 1 | Conversion-complete strobe |
| adc_result | input | DATA_W | Finished conversion result |
| cmd_wr | output | 1 | Write strobe to the converter command register |
| cmd_word | output | DATA_W | Command word for the converter |
| host_we | input | 1 | Host table write |
| host_re | input | 1 | Host table read |
| host_addr | input | ADDR_W-1 | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Data of the last table read |
| busy | output | 1 | Transfer cycle in progress |
| seq_en | output | 1 | Sequencer enabled |
| done_irq | output | 1 | One-cycle pulse when the count runs out |

## Verification
The hardest case to reach from the ports is a collision during the four-cycle transfer window. In that window a second conversion strobe, a host write and a reconfiguration load must all be dropped, while the cycle in flight still finishes with the first result. The stimulus lines up all three events in the clock right after an accepted strobe. It then reads the table back and checks the enable flag to show that none of them took effect. The terminal cycle is also exercised in both pointer modes: the done pulse has to land exactly one clock after the last command write, and a further strobe must then produce nothing.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LATCH = 3'd2,
    ST_STORE = 3'd3,
    ST_ISSUE = 3'd4
  } seq_state_t;

  localparam logic [2:0] MODE_SCAN = 3'b110;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_updt,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic              busy,
  input  logic              cycle_end,
  input  logic [ADDR_W-1:0] ptr_adv,
  output logic              en,
  output logic [ADDR_W-1:0] ptr,
  output logic              done_irq
);
  import adc_scan_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             updt;

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(1);
  endfunction

  wire load_ok    = cfg_load && !busy;
  wire last_cycle = cycle_end && (cnt == CNT_W'(1));
  wire arm_ok     = (cfg_mode == MODE_SCAN) && (cfg_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      ptr      <= '0;
      cnt      <= '0;
      updt     <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (load_ok) begin
        en   <= arm_ok;
        ptr  <= word_align(cfg_ptr);
        cnt  <= cfg_count;
        updt <= cfg_updt;
      end else if (cycle_end) begin
        cnt <= count_dec(cnt);
        if (updt) ptr <= ptr_adv;
        if (last_cycle) begin
          en       <= 1'b0;
          done_irq <= 1'b1;
        end
      end
    end
  end

  // R7: the terminal cycle switches the block off and raises the interrupt
  assert_last_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_cycle |=> (!en && done_irq));

  // R7: the count steps down by one on every non-terminal cycle
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !last_cycle) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R7: the interrupt lasts a single clock
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R5: with the update flag clear the pointer snaps back
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !updt) |=> (ptr == $past(ptr)));

  // R6: with the update flag set the pointer takes the advanced value
  assert_ptr_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && updt) |=> (ptr == $past(ptr_adv)));

  // R8: a load during a transfer leaves the pointer alone
  assert_busy_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && busy && !cycle_end) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int WORD_AW = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_done,
  input  logic               en,
  input  logic [DATA_W-1:0]  adc_result,
  input  logic [ADDR_W-1:0]  ptr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               busy,
  output logic               cycle_end,
  output logic [ADDR_W-1:0]  ptr_adv,
  output logic               seq_re,
  output logic               seq_we,
  output logic [WORD_AW-1:0] seq_addr,
  output logic [DATA_W-1:0]  seq_wdata,
  output logic               cmd_wr,
  output logic [DATA_W-1:0]  cmd_word
);
  import adc_scan_pkg::*;

  seq_state_t        state;
  logic [ADDR_W-1:0] wptr;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] tmp_cmd;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(2);
  endfunction

  wire start = (state == ST_IDLE) && conv_done && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wptr    <= '0;
      res_q   <= '0;
      tmp_cmd <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          res_q <= adc_result;
          wptr  <= ptr;
          state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: begin
          tmp_cmd <= mem_rdata;
          wptr    <= bump(wptr);
          state   <= ST_STORE;
        end
        ST_STORE: begin
          wptr  <= bump(wptr);
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    seq_re    = (state == ST_FETCH);
    seq_we    = (state == ST_STORE);
    cmd_wr    = (state == ST_ISSUE);
    cycle_end = cmd_wr;
    seq_addr  = wptr[ADDR_W-1:1];
    seq_wdata = res_q;
    cmd_word  = tmp_cmd;
    ptr_adv   = wptr;
  end

  // R1: no strobe while enabled means the sequencer stays idle
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !(conv_done && en)) |=> !busy);

  // R3: the result goes one word above the fetched command
  assert_store_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |-> (seq_addr == $past(seq_addr, 2) + WORD_AW'(1)));

  // R4: the command is issued right after the store
  assert_issue_after_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> $past(seq_we));

  // R2: the issued word is the one the fetch returned
  assert_cmd_fetched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_word == $past(mem_rdata, 2)));
endmodule

// File: rtl/adc_scan_mem.sv
module adc_scan_mem #(
  parameter int WORD_AW = 7,
  parameter int DATA_W  = 16,
  localparam int DEPTH  = 1 << WORD_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               re,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

  // R9: the single port never sees a read and a write in one clock
  assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int WORD_AW = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [2:0]         cfg_mode,
  input  logic               cfg_updt,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic [ADDR_W-1:0]  cfg_ptr,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  adc_result,
  output logic               cmd_wr,
  output logic [DATA_W-1:0]  cmd_word,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [WORD_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               busy,
  output logic               seq_en,
  output logic               done_irq
);
  logic               cycle_end;
  logic [ADDR_W-1:0]  ptr;
  logic [ADDR_W-1:0]  ptr_adv;
  logic               seq_re, seq_we;
  logic [WORD_AW-1:0] seq_addr;
  logic [DATA_W-1:0]  seq_wdata;
  logic               mem_we, mem_re;
  logic [WORD_AW-1:0] mem_addr;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  mem_rdata;

  adc_scan_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_updt(cfg_updt),
    .cfg_count(cfg_count), .cfg_ptr(cfg_ptr),
    .busy(busy), .cycle_end(cycle_end), .ptr_adv(ptr_adv),
    .en(seq_en), .ptr(ptr), .done_irq(done_irq)
  );

  adc_scan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .conv_done(conv_done), .en(seq_en), .adc_result(adc_result),
    .ptr(ptr), .mem_rdata(mem_rdata),
    .busy(busy), .cycle_end(cycle_end), .ptr_adv(ptr_adv),
    .seq_re(seq_re), .seq_we(seq_we), .seq_addr(seq_addr),
    .seq_wdata(seq_wdata), .cmd_wr(cmd_wr), .cmd_word(cmd_word)
  );

  always_comb begin
    if (busy) begin
      mem_we    = seq_we;
      mem_re    = seq_re;
      mem_addr  = seq_addr;
      mem_wdata = seq_wdata;
    end else begin
      mem_we    = host_we;
      mem_re    = host_re && !host_we;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end
  end

  adc_scan_mem #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign host_rdata = mem_rdata;

  // R9: during a transfer only the sequencer writes the table
  assert_host_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we) |-> seq_we);
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int WORD_AW = ADDR_W - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_load = 1'b0;
  logic [2:0]         cfg_mode = '0;
  logic               cfg_updt = 1'b0;
  logic [CNT_W-1:0]   cfg_count = '0;
  logic [ADDR_W-1:0]  cfg_ptr = '0;
  logic               conv_done = 1'b0;
  logic [DATA_W-1:0]  adc_result = '0;
  logic               cmd_wr;
  logic [DATA_W-1:0]  cmd_word;
  logic               host_we = 1'b0;
  logic               host_re = 1'b0;
  logic [WORD_AW-1:0] host_addr = '0;
  logic [DATA_W-1:0]  host_wdata = '0;
  logic [DATA_W-1:0]  host_rdata;
  logic               busy, seq_en, done_irq;

  always #5 clk = ~clk;

  adc_scan_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_updt(cfg_updt),
    .cfg_count(cfg_count), .cfg_ptr(cfg_ptr),
    .conv_done(conv_done), .adc_result(adc_result),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .seq_en(seq_en), .done_irq(done_irq)
  );

  typedef struct packed {
    logic [DATA_W-1:0] cmd;
    logic              last;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   chk_done = 1'b0;
  logic exp_last = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected command writes and checks the done pulse after each
  always @(negedge clk) begin
    if (chk_done) begin
      check(done_irq == exp_last, "R7 done pulse after command write", done_irq, exp_last);
      chk_done = 1'b0;
    end
    if (rst_n && cmd_wr) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 command write with no accepted strobe", cmd_word, 0);
      end else begin
        cur = q.pop_front();
        check(cmd_word == cur.cmd, "R4 re-issued command word", cmd_word, cur.cmd);
        exp_last = cur.last;
        chk_done = 1'b1;
      end
    end
  end

  task automatic host_write(input logic [WORD_AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_read(input logic [WORD_AW-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    @(negedge clk); host_re = 1'b0; d = host_rdata;
  endtask

  task automatic load_cfg(input logic [2:0] m, input logic u, input logic [CNT_W-1:0] c,
                          input logic [ADDR_W-1:0] p);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_updt = u; cfg_count = c; cfg_ptr = p;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // driver: pushes the expected command, then pulses the strobe and checks the busy window
  task automatic convert(input logic [DATA_W-1:0] res, input logic [DATA_W-1:0] cmd, input logic last);
    q.push_back('{cmd: cmd, last: last});
    @(negedge clk); conv_done = 1'b1; adc_result = res;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 1) begin conv_done = 1'b0; adc_result = 16'hFFFF; end
      check(busy == (i <= 4), "R4 busy window", busy, (i <= 4));
    end
    @(negedge clk);
  endtask

  task automatic convert_ignored(input logic [DATA_W-1:0] res);
    @(negedge clk); conv_done = 1'b1; adc_result = res;
    @(negedge clk); conv_done = 1'b0;
    check(busy == 1'b0, "R1 ignored strobe leaves block idle", busy, 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R8 reset busy", busy, 0);
    check(seq_en == 1'b0, "R8 reset enable", seq_en, 0);
    check(cmd_wr == 1'b0, "R8 reset command strobe", cmd_wr, 0);
    check(done_irq == 1'b0, "R8 reset interrupt", done_irq, 0);

    // table setup and host port round trip
    host_write(7'd8, 16'h1234);
    host_write(7'd9, 16'h0000);
    host_write(7'd50, 16'h5555);
    host_read(7'd8, rd);
    check(rd == 16'h1234, "R9 host read back", rd, 16'h1234);

    // wrong mode does not arm the sequencer
    load_cfg(3'b010, 1'b0, 8'd3, 8'h10);
    check(seq_en == 1'b0, "R8 non-scan mode stays disabled", seq_en, 0);
    convert_ignored(16'h0BAD);
    host_read(7'd9, rd);
    check(rd == 16'h0000, "R1 disabled strobe leaves slot", rd, 16'h0000);

    // pointer snaps back: same command, same slot; odd pointer is aligned
    load_cfg(3'b110, 1'b0, 8'd3, 8'h11);
    check(seq_en == 1'b1, "R8 scan mode arms", seq_en, 1);
    convert(16'hAAA1, 16'h1234, 1'b0);
    host_read(7'd9, rd);
    check(rd == 16'hAAA1, "R3 result stored one word above command", rd, 16'hAAA1);
    convert(16'hAAA2, 16'h1234, 1'b0);
    convert(16'hAAA3, 16'h1234, 1'b1);
    check(seq_en == 1'b0, "R7 disabled after last cycle", seq_en, 0);
    host_read(7'd9, rd);
    check(rd == 16'hAAA3, "R5 slot overwritten with latest result", rd, 16'hAAA3);
    host_read(7'd8, rd);
    check(rd == 16'h1234, "R5 command word untouched", rd, 16'h1234);
    convert_ignored(16'h0BAD);
    host_read(7'd9, rd);
    check(rd == 16'hAAA3, "R7 strobe after count expiry ignored", rd, 16'hAAA3);

    // pointer walks through pairs
    host_write(7'd32, 16'h0C01);
    host_write(7'd34, 16'h0C02);
    host_write(7'd36, 16'h0C03);
    load_cfg(3'b110, 1'b1, 8'd3, 8'h40);
    convert(16'hB001, 16'h0C01, 1'b0);
    convert(16'hB002, 16'h0C02, 1'b0);
    convert(16'hB003, 16'h0C03, 1'b1);
    host_read(7'd33, rd);
    check(rd == 16'hB001, "R6 first pair result", rd, 16'hB001);
    host_read(7'd35, rd);
    check(rd == 16'hB002, "R6 second pair result", rd, 16'hB002);
    host_read(7'd37, rd);
    check(rd == 16'hB003, "R6 third pair result", rd, 16'hB003);
    host_read(7'd34, rd);
    check(rd == 16'h0C02, "R6 commands preserved", rd, 16'h0C02);

    // collisions during a transfer: strobe, host write and load all dropped
    load_cfg(3'b110, 1'b0, 8'd2, 8'h40);
    q.push_back('{cmd: 16'h0C01, last: 1'b0});
    @(negedge clk); conv_done = 1'b1; adc_result = 16'hC001;
    @(negedge clk);
    adc_result = 16'hDEAD;
    host_we = 1'b1; host_addr = 7'd50; host_wdata = 16'hFFFF;
    cfg_load = 1'b1; cfg_mode = 3'b010; cfg_updt = 1'b1; cfg_count = 8'd1; cfg_ptr = 8'h60;
    @(negedge clk);
    conv_done = 1'b0; host_we = 1'b0; cfg_load = 1'b0;
    repeat (6) @(negedge clk);
    check(seq_en == 1'b1, "R8 load during transfer ignored", seq_en, 1);
    host_read(7'd33, rd);
    check(rd == 16'hC001, "R2 result sampled at strobe, busy strobe dropped (R1)", rd, 16'hC001);
    host_read(7'd50, rd);
    check(rd == 16'h5555, "R9 host write during transfer ignored", rd, 16'h5555);
    convert(16'hC002, 16'h0C01, 1'b1);
    host_read(7'd33, rd);
    check(rd == 16'hC002, "R5 same slot after reconfig attempt", rd, 16'hC002);

    // zero count does not arm
    load_cfg(3'b110, 1'b0, 8'd0, 8'h10);
    check(seq_en == 1'b0, "R8 zero count stays disabled", seq_en, 0);
    convert_ignored(16'h0BAD);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4 all expected command writes seen", q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule